// File: doc/BRIEF.md
# Dual Reference Clock Selector with Stop Detection

The block chooses one of two reference clocks to drive a single output clock. A free-running supervisory clock watches both references. Each reference drives a toggle flop in its own domain, and that toggle is resynchronized into the supervisory domain. When no toggle change is seen for a set number of supervisory cycles, a per-input "stopped" flag goes high. A second flag, the switch-condition flag, is high while the active input is stopped or while the downstream PLL reports that it is not locked.

Software or a pin can pick the input with a level request, which may be asynchronous. The block honours a change of that request only while both references are running. The block fails over to the other input on its own when the active input stops or when the lock status falls, provided the other input is healthy. The output mux hands over with cross-coupled enables that change on falling clock edges, so the output sits low during the handoff and never carries a shortened pulse.

Top module: `clk_failover_sel`

## Requirements
- R1: While the synchronous reset is high, the selection reads 0 (input clock 0), both stopped flags read 0 and the switch-condition flag reads 0.
- R2: A change of the synchronized select request, made while neither input is flagged stopped, sets the selection to the request level: low selects input 0, high selects input 1.
- R3: A change of the select request made while either input is flagged stopped is ignored. The selection keeps its value.
- R4: The stopped flag of input i (bit i of the flag vector) rises once IDLE_LIM supervisory cycles pass with no toggle change observed from that input. It stays low while the input is running.
- R5: A raised stopped flag clears only after IDLE_LIM consecutive windows of IDLE_LIM supervisory cycles, each of which contains at least one observed toggle change.
- R6: The switch-condition flag is high exactly while the active input is flagged stopped or the synchronized lock status is low. A stopped flag on the inactive input does not raise it.
- R7: A falling edge of the lock status moves the selection to the other input, if that input is not flagged stopped.
- R8: When the active input is flagged stopped and the other is not, the selection moves to the other input on the next supervisory cycle.
- R9: When both inputs are flagged stopped, the selection does not change and the switch-condition flag stays high.
- R10: At most one mux enable is high at any time. Once a handoff completes, the output follows the selected input. The output holds low while the selected input is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sup_clk | input | 1 | Always-on supervisory clock |
| rst | input | 1 | Synchronous active-high reset, supervisory domain |
| ref_clk0 | input | 1 | Reference clock input 0 |
| ref_clk1 | input | 1 | Reference clock input 1 |
| sw_req | input | 1 | Manual select request level, asynchronous (0 selects input 0) |
| pll_locked | input | 1 | Lock status from the downstream PLL, asynchronous |
| clk_out | output | 1 | Selected, glitch-free output clock |
| sel_src | output | 1 | Current selection in the supervisory domain |
| clk_bad | output | 2 | Per-input stopped flags, bit i for input i |
| switch_cond | output | 1 | Switch condition detected |

## Verification
On every supervisory cycle the assertions check several properties. At most one mux enable is high. The selection moves whenever the active input is stopped and the other is healthy. The selection holds and the switch-condition flag stays up whenever both inputs are stopped. The reset state is correct. The stimulus scenarios are needed for the behaviour that only shows over time or at the clock pins. This covers the window in which a stopped flag rises, the long recovery before it clears, requests ignored while an input is stopped, lock-loss failover, and the output clock following the chosen reference after each handoff.

// File: rtl/clk_failover_pkg.sv
package clk_failover_pkg;

    typedef enum logic {
        SRC0 = 1'b0,
        SRC1 = 1'b1
    } src_e;

    typedef struct packed {
        logic req_lvl;
        logic req_edge;
        logic lock_lvl;
        logic lock_fall;
    } ctl_sync_t;

    function automatic src_e flip_src(input src_e s);
        return (s == SRC0) ? SRC1 : SRC0;
    endfunction

    function automatic logic [1:0] src_onehot(input src_e s);
        return (s == SRC0) ? 2'b01 : 2'b10;
    endfunction

endpackage

// File: rtl/clk_act_mon.sv
module clk_act_mon #(
    parameter int IDLE_LIM = 16
) (
    input  logic sup_clk,
    input  logic rst,
    input  logic ref_clk,
    output logic bad
);
    localparam int CW = $clog2(IDLE_LIM + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_LIM - 1);

    logic          rst_q;
    logic          tog;
    logic [2:0]    smp;
    logic          change;
    logic [CW-1:0] idle_cnt;
    logic [CW-1:0] win_cnt;
    logic [CW-1:0] streak;
    logic          seen;

    always_ff @(posedge sup_clk) begin
        rst_q <= rst;
    end

    always_ff @(posedge ref_clk or posedge rst_q) begin
        if (rst_q) tog <= 1'b0;
        else       tog <= ~tog;
    end

    always_ff @(posedge sup_clk) begin
        if (rst) smp <= '0;
        else     smp <= {smp[1:0], tog};
    end

    assign change = smp[2] ^ smp[1];

    always_ff @(posedge sup_clk) begin
        if (rst || change)     idle_cnt <= '0;
        else if (idle_cnt != LAST) idle_cnt <= idle_cnt + 1'b1;
    end

    always_ff @(posedge sup_clk) begin
        if (rst) begin
            bad     <= 1'b0;
            win_cnt <= '0;
            streak  <= '0;
            seen    <= 1'b0;
        end else if (!bad) begin
            win_cnt <= '0;
            streak  <= '0;
            seen    <= 1'b0;
            if (!change && idle_cnt == LAST) bad <= 1'b1;
        end else if (win_cnt == LAST) begin
            win_cnt <= '0;
            seen    <= 1'b0;
            if (seen || change) begin
                if (streak == LAST) begin
                    bad    <= 1'b0;
                    streak <= '0;
                end else begin
                    streak <= streak + 1'b1;
                end
            end else begin
                streak <= '0;
            end
        end else begin
            win_cnt <= win_cnt + 1'b1;
            seen    <= seen | change;
        end
    end

endmodule

// File: rtl/clk_sel_ctrl.sv
module clk_sel_ctrl
    import clk_failover_pkg::*;
(
    input  logic       sup_clk,
    input  logic       rst,
    input  logic       sw_req,
    input  logic       pll_locked,
    input  logic [1:0] bad,
    output src_e       sel,
    output logic       loss,
    output logic [1:0] want,
    output logic [1:0] kill
);
    logic [2:0] req_q;
    logic [2:0] lock_q;
    ctl_sync_t  cs;
    src_e       sel_nxt;
    logic       cur_bad;
    logic       oth_bad;

    always_ff @(posedge sup_clk) begin
        if (rst) begin
            req_q  <= '0;
            lock_q <= '0;
        end else begin
            req_q  <= {req_q[1:0], sw_req};
            lock_q <= {lock_q[1:0], pll_locked};
        end
    end

    always_comb begin
        cs.req_lvl   = req_q[1];
        cs.req_edge  = req_q[1] ^ req_q[2];
        cs.lock_lvl  = lock_q[1];
        cs.lock_fall = lock_q[2] & ~lock_q[1];
    end

    always_comb begin
        cur_bad = bad[sel];
        oth_bad = bad[flip_src(sel)];
        sel_nxt = sel;
        if ((cur_bad || cs.lock_fall) && !oth_bad)
            sel_nxt = flip_src(sel);
        else if (cs.req_edge && bad == 2'b00)
            sel_nxt = cs.req_lvl ? SRC1 : SRC0;
    end

    always_ff @(posedge sup_clk) begin
        if (rst) begin
            sel  <= SRC0;
            loss <= 1'b0;
            want <= 2'b00;
            kill <= 2'b11;
        end else begin
            sel  <= sel_nxt;
            loss <= cur_bad | ~cs.lock_lvl;
            want <= src_onehot(sel);
            kill <= bad & ~src_onehot(sel);
        end
    end

endmodule

// File: rtl/clk_gf_mux.sv
module clk_gf_mux #(
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0] ref_clk,
    input  logic [NSRC-1:0] want,
    input  logic [NSRC-1:0] kill,
    output logic [NSRC-1:0] en,
    output logic            clk_out
);
    for (genvar g = 0; g < NSRC; g++) begin : g_branch
        localparam int OTH = (g + 1) % NSRC;
        logic [1:0] sy;
        logic       en_q;

        always_ff @(negedge ref_clk[g] or posedge kill[g]) begin
            if (kill[g]) begin
                sy   <= 2'b00;
                en_q <= 1'b0;
            end else begin
                sy   <= {sy[0], want[g] & ~en[OTH]};
                en_q <= sy[1];
            end
        end

        assign en[g] = en_q;
    end

    always_comb begin
        clk_out = |(ref_clk & en);
    end

endmodule

// File: rtl/clk_failover_sel.sv
module clk_failover_sel
    import clk_failover_pkg::*;
#(
    parameter int IDLE_LIM = 16
) (
    input  logic       sup_clk,
    input  logic       rst,
    input  logic       ref_clk0,
    input  logic       ref_clk1,
    input  logic       sw_req,
    input  logic       pll_locked,
    output logic       clk_out,
    output logic       sel_src,
    output logic [1:0] clk_bad,
    output logic       switch_cond
);
    logic [1:0] refs;
    logic [1:0] want;
    logic [1:0] kill;
    logic [1:0] gate_en;
    src_e       sel;

    assign refs = {ref_clk1, ref_clk0};

    for (genvar g = 0; g < 2; g++) begin : g_mon
        clk_act_mon #(.IDLE_LIM(IDLE_LIM)) u_mon (
            .sup_clk (sup_clk),
            .rst     (rst),
            .ref_clk (refs[g]),
            .bad     (clk_bad[g])
        );
    end

    clk_sel_ctrl u_ctrl (
        .sup_clk    (sup_clk),
        .rst        (rst),
        .sw_req     (sw_req),
        .pll_locked (pll_locked),
        .bad        (clk_bad),
        .sel        (sel),
        .loss       (switch_cond),
        .want       (want),
        .kill       (kill)
    );

    clk_gf_mux #(.NSRC(2)) u_mux (
        .ref_clk (refs),
        .want    (want),
        .kill    (kill),
        .en      (gate_en),
        .clk_out (clk_out)
    );

    assign sel_src = sel;

endmodule

// File: rtl/clk_failover_chk.sv
module clk_failover_chk (
    input logic       clk,
    input logic       rst,
    input logic       sel,
    input logic [1:0] bad,
    input logic       loss,
    input logic [1:0] en
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (sel == 1'b0 && bad == 2'b00 && loss == 1'b0));

    // R8
    a_r8_failover_on_stop: assert property (@(posedge clk) disable iff (rst)
        (bad[sel] && !bad[~sel]) |=> (sel != $past(sel)));

    // R9
    a_r9_hold_when_both_bad: assert property (@(posedge clk) disable iff (rst)
        (bad == 2'b11) |=> (sel == $past(sel)));

    // R9
    a_r9_loss_held: assert property (@(posedge clk) disable iff (rst)
        (bad == 2'b11) |=> loss);

    // R10
    a_r10_one_enable: assert property (@(posedge clk) disable iff (rst)
        $countones(en) <= 1);

endmodule

bind clk_failover_sel clk_failover_chk u_chk (
    .clk  (sup_clk),
    .rst  (rst),
    .sel  (sel_src),
    .bad  (clk_bad),
    .loss (switch_cond),
    .en   (gate_en)
);

// File: tb/clk_failover_sel_tb.sv
module clk_failover_sel_tb;
    localparam int N = 8;

    logic sup_clk = 1'b0;
    logic rst = 1'b1;
    logic ref0 = 1'b0;
    logic ref1 = 1'b0;
    logic run0 = 1'b1;
    logic run1 = 1'b1;
    logic sw_req = 1'b0;
    logic pll_locked = 1'b1;
    logic clk_out;
    logic sel_src;
    logic [1:0] clk_bad;
    logic switch_cond;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    clk_failover_sel #(.IDLE_LIM(N)) u_dut (
        .sup_clk     (sup_clk),
        .rst         (rst),
        .ref_clk0    (ref0),
        .ref_clk1    (ref1),
        .sw_req      (sw_req),
        .pll_locked  (pll_locked),
        .clk_out     (clk_out),
        .sel_src     (sel_src),
        .clk_bad     (clk_bad),
        .switch_cond (switch_cond)
    );

    always #10 sup_clk = ~sup_clk;
    always begin #15; ref0 = run0 ? ~ref0 : 1'b0; end
    always begin #25; ref1 = run1 ? ~ref1 : 1'b0; end

    task automatic cyc(input int n);
        repeat (n) @(posedge sup_clk);
        #3;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // output must equal the expected reference at sampled instants
    task automatic chk_follow(input string req, input int src);
        int bad_smp = 0;
        for (int k = 0; k < 40; k++) begin
            if (clk_out !== ((src == 0) ? ref0 : ref1)) bad_smp++;
            cyc(1);
        end
        check(bad_smp == 0, req, bad_smp, 0);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            report();
        end
    end

    initial begin
        cyc(4);
        // R1: state held in reset
        chk_eq("R1 sel", sel_src, 0);
        chk_eq("R1 bad", clk_bad, 0);
        chk_eq("R1 loss", switch_cond, 0);
        rst = 1'b0;
        cyc(60);
        chk_eq("R6 loss idle", switch_cond, 0);
        chk_follow("R10 follow ref0", 0);

        // R2: manual to input 1 then back
        sw_req = 1'b1;
        cyc(60);
        chk_eq("R2 sel=1", sel_src, 1);
        chk_follow("R10 follow ref1", 1);
        sw_req = 1'b0;
        cyc(60);
        chk_eq("R2 sel=0", sel_src, 0);

        // R4: stop inactive input 1
        run1 = 1'b0;
        cyc(N - 5);
        chk_eq("R4 not yet bad", clk_bad, 0);
        cyc(11);
        chk_eq("R4 bad1", clk_bad, 2);
        chk_eq("R6 inactive bad no loss", switch_cond, 0);

        // R3: request ignored with input 1 stopped
        sw_req = 1'b1;
        cyc(20);
        chk_eq("R3 ignored", sel_src, 0);

        // R5: recovery window
        run1 = 1'b1;
        cyc((N - 1) * N - 1);
        chk_eq("R5 still bad", clk_bad, 2);
        cyc(23);
        chk_eq("R5 cleared", clk_bad, 0);
        chk_eq("R3 sel kept after recovery", sel_src, 0);
        sw_req = 1'b0;
        cyc(20);

        // R7: lock loss failover
        pll_locked = 1'b0;
        cyc(6);
        chk_eq("R7 sel", sel_src, 1);
        chk_eq("R6 loss unlocked", switch_cond, 1);
        pll_locked = 1'b1;
        cyc(6);
        chk_eq("R6 loss relock", switch_cond, 0);
        cyc(54);
        chk_follow("R10 follow ref1 after lock loss", 1);

        // R8: active input 1 stops
        run1 = 1'b0;
        cyc(N + 10);
        chk_eq("R8 sel", sel_src, 0);
        chk_eq("R8 bad", clk_bad, 2);
        chk_eq("R6 loss after failover", switch_cond, 0);
        cyc(60);
        chk_follow("R10 follow ref0 after failover", 0);

        // R9: both stopped
        run0 = 1'b0;
        cyc(N + 10);
        chk_eq("R9 bad", clk_bad, 3);
        chk_eq("R9 sel", sel_src, 0);
        chk_eq("R9 loss", switch_cond, 1);
        chk_eq("R10 output low", clk_out, 0);

        // input 0 comes back
        run0 = 1'b1;
        cyc((N + 1) * N + 10);
        chk_eq("R5 bad0 cleared", clk_bad, 2);
        chk_eq("R6 loss cleared", switch_cond, 0);
        chk_follow("R10 follow ref0 after restart", 0);

        done = 1;
        report();
    end

endmodule